// File: doc/BRIEF.md
# Full-Bridge Gate Sequencer

This block converts a one-bit direction command into four gate enables for an H-bridge: A-low, A-high, B-low and B-high. A high-side enable can hold both upper switches off while the lower switches keep following the direction. A disable request or an undervoltage flag forces every gate low. Every gate turns on only after a programmable delay, and no gate turns on while the other switch of its leg is on or requested. Every gate turns off on the next clock edge.

When the disable request and the undervoltage flag are both released, the block runs a start-up sequence. Both low switches are pulsed on together so that the bootstrap capacitors recharge. The upper switches stay blocked until a separate upper-enable interval has elapsed. All delays, hold times and intervals are counted in clock cycles and come from static configuration inputs. These inputs may change only while reset is asserted. The direction, high-side enable, disable and undervoltage inputs each pass through a two-flop synchronizer. The block contains no analog parts and does not drive the gates electrically.

Top module: `bridge_gate_seq`

## Requirements
- R1: While reset is asserted, and after reset until a release is seen, all four gates are low and the block counts as disabled.
- R2: Raising disReq drives all four gates low no later than the third rising clock edge after the input changes, whatever the other inputs are.
- R3: Raising uvFlag has exactly the same effect as disReq: all four gates are low no later than the third edge.
- R4: In normal running with hiSideEn high, direction 1 turns on gateAHi and gateBLo, and direction 0 turns on gateALo and gateBHi. The other two gates stay off.
- R5: With hiSideEn low, gateAHi and gateBHi are held off. The low gates still follow the direction: 1 gives gateBLo only and 0 gives gateALo only.
- R6: A high gate rises hiDelay+1 edges after its request rises, and never while the low gate of its leg is on or requested. It falls on the first edge after its request drops.
- R7: A low gate rises loDelay+1 edges after its request rises, with the same leg interlock. It falls on the first edge after its request drops.
- R8: In no cycle is the high gate and the low gate of the same leg on together, for any input sequence or configuration.
- R9: When the synchronized disable and undervoltage signals are both seen low, a refresh phase of max(1, refreshLen) cycles starts. During the refresh both low gates turn on together one edge after it begins, with no loDelay applied, and both high gates stay off.
- R10: Counting from the first refresh cycle, no high gate is requested until max(max(1, refreshLen), upperLen) cycles have passed.
- R11: A change of the synchronized direction from 0 to 1 is accepted only after the new level has held for riseHold+1 consecutive cycles. A change from 1 to 0 needs fallHold+1 cycles. Shorter pulses leave the gates unchanged.
- R12: A disable or undervoltage that arrives during the refresh or upper-enable wait aborts the sequence: all gates go low on the next edge, and the next release starts the refresh from the beginning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| dirCmd | input | 1 | Bridge direction command (asynchronous) |
| hiSideEn | input | 1 | Permits the high-side gates when 1 (asynchronous) |
| disReq | input | 1 | Forces all gates off when 1 (asynchronous) |
| uvFlag | input | 1 | Undervoltage indication; forces all gates off when 1 |
| hiDelay | input | CW | Turn-on delay of the high gates, in cycles |
| loDelay | input | CW | Turn-on delay of the low gates, in cycles |
| riseHold | input | CW | Extra cycles a 0-to-1 direction change must hold |
| fallHold | input | CW | Extra cycles a 1-to-0 direction change must hold |
| refreshLen | input | CW | Length of the bootstrap refresh phase, in cycles |
| upperLen | input | CW | Cycles from release until the high gates are permitted |
| gateALo | output | 1 | Gate enable, leg A low switch |
| gateAHi | output | 1 | Gate enable, leg A high switch |
| gateBLo | output | 1 | Gate enable, leg B low switch |
| gateBHi | output | 1 | Gate enable, leg B high switch |

## Verification
The hardest case to reach is a disable that lands inside the short refresh window. That window opens only three edges after release and lasts just refreshLen cycles. The bench re-asserts disReq exactly three cycles after a release, and does this in every configuration of a sweep over the delays, holds and intervals, so that for the longer refresh length the kill is seen mid-refresh. Glitches on the direction input that are one to three cycles wide are also swept against each pair of hold settings. This checks that pulses at the acceptance boundary are either rejected or accepted exactly.

// File: rtl/bgs_pkg.sv
package bgs_pkg;

  typedef enum logic [1:0] {
    PH_OFF,
    PH_REFRESH,
    PH_HOLDHI,
    PH_RUN
  } phase_t;

  // strobes from the control to the gate datapath
  typedef struct packed {
    logic allOff;
    logic refresh;
    logic hiAllow;
    logic dir;
    logic hiEn;
  } strobe_t;

endpackage

// File: rtl/bgs_ctrl.sv
module bgs_ctrl
  import bgs_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          dirIn,
  input  logic          hiEnIn,
  input  logic          disIn,
  input  logic          uvIn,
  input  logic [CW-1:0] riseHold,
  input  logic [CW-1:0] fallHold,
  input  logic [CW-1:0] refreshLen,
  input  logic [CW-1:0] upperLen,
  output strobe_t       strb
);

  localparam int NSYNC = 4;
  localparam logic [NSYNC-1:0] SYNC_RST = 4'b0010;

  logic [NSYNC-1:0] syncA, syncB;
  logic dirS, hiEnS, killS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= SYNC_RST;
      syncB <= SYNC_RST;
    end else begin
      syncA <= {dirIn, hiEnIn, disIn, uvIn};
      syncB <= syncA;
    end
  end

  assign dirS  = syncB[3];
  assign hiEnS = syncB[2];
  assign killS = syncB[1] | syncB[0];

  // direction qualification: minimum on / off persistence
  logic          dirF;
  logic [CW-1:0] qualCnt;
  logic [CW-1:0] holdThr;

  assign holdThr = dirS ? riseHold : fallHold;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirF    <= 1'b0;
      qualCnt <= '0;
    end else if (dirS == dirF) begin
      qualCnt <= '0;
    end else if (qualCnt >= holdThr) begin
      dirF    <= dirS;
      qualCnt <= '0;
    end else begin
      qualCnt <= qualCnt + 1'b1;
    end
  end

  // start-up phase machine
  phase_t      phase;
  logic [CW:0] tCnt, tNext;

  assign tNext = tCnt + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_OFF;
      tCnt  <= '0;
    end else if (killS) begin
      phase <= PH_OFF;
      tCnt  <= '0;
    end else begin
      case (phase)
        PH_OFF: begin
          phase <= PH_REFRESH;
          tCnt  <= '0;
        end
        PH_REFRESH: begin
          tCnt <= tNext;
          if (tNext >= {1'b0, refreshLen})
            phase <= (tNext >= {1'b0, upperLen}) ? PH_RUN : PH_HOLDHI;
        end
        PH_HOLDHI: begin
          tCnt <= tNext;
          if (tNext >= {1'b0, upperLen}) phase <= PH_RUN;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    strb.allOff  = (phase == PH_OFF) | killS;
    strb.refresh = (phase == PH_REFRESH);
    strb.hiAllow = (phase == PH_RUN);
    strb.dir     = dirF;
    strb.hiEn    = hiEnS;
  end

  p_kill_to_off_r2: assert property (@(posedge clk) disable iff (!rstN)
    killS |=> (phase == PH_OFF));

  p_release_refresh_r9: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_OFF && !killS) |=> (phase == PH_REFRESH));

  p_run_after_upper_r10: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_RUN) |-> (tCnt >= {1'b0, upperLen}));

  p_dir_needs_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (dirS != dirF && qualCnt < holdThr) |=> $stable(dirF));

endmodule

// File: rtl/bgs_datapath.sv
module bgs_datapath
  import bgs_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       strb,
  input  logic [CW-1:0] hiDelay,
  input  logic [CW-1:0] loDelay,
  output logic [3:0]    gateQ
);

  // index: 0 A-low, 1 A-high, 2 B-low, 3 B-high; leg mate is index ^ 1
  localparam int NSW = 4;

  logic [NSW-1:0] req;

  always_comb begin
    req[0] = !strb.allOff && (strb.refresh || !strb.dir);
    req[1] = !strb.allOff && !strb.refresh && strb.hiAllow && strb.hiEn && strb.dir;
    req[2] = !strb.allOff && (strb.refresh || strb.dir);
    req[3] = !strb.allOff && !strb.refresh && strb.hiAllow && strb.hiEn && !strb.dir;
  end

  for (genvar i = 0; i < NSW; i++) begin : g_sw
    localparam int MATE  = i ^ 1;
    localparam bit IS_HI = (i % 2) == 1;

    logic          swQ;
    logic [CW-1:0] cnt;
    logic [CW-1:0] dly;
    logic          goOn;

    assign dly  = IS_HI ? hiDelay : loDelay;
    assign goOn = !gateQ[MATE] && !req[MATE] &&
                  ((cnt >= dly) || (!IS_HI && strb.refresh));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        swQ <= 1'b0;
        cnt <= '0;
      end else if (!req[i]) begin
        swQ <= 1'b0;
        cnt <= '0;
      end else if (!swQ) begin
        if (goOn) swQ <= 1'b1;
        else if (cnt != '1) cnt <= cnt + 1'b1;
      end
    end

    assign gateQ[i] = swQ;
  end

  p_leg_a_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(gateQ[0] && gateQ[1]));

  p_leg_b_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(gateQ[2] && gateQ[3]));

  p_hi_off_fast_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!req[1] && !req[3]) |=> (!gateQ[1] && !gateQ[3]));

  p_lo_off_fast_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!req[0] && !req[2]) |=> (!gateQ[0] && !gateQ[2]));

  p_hen_low_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strb.hiEn |=> (!gateQ[1] && !gateQ[3]));

  p_abort_all_off_r12: assert property (@(posedge clk) disable iff (!rstN)
    strb.allOff |=> (gateQ == '0));

endmodule

// File: rtl/bridge_gate_seq.sv
module bridge_gate_seq
  import bgs_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          dirCmd,
  input  logic          hiSideEn,
  input  logic          disReq,
  input  logic          uvFlag,
  input  logic [CW-1:0] hiDelay,
  input  logic [CW-1:0] loDelay,
  input  logic [CW-1:0] riseHold,
  input  logic [CW-1:0] fallHold,
  input  logic [CW-1:0] refreshLen,
  input  logic [CW-1:0] upperLen,
  output logic          gateALo,
  output logic          gateAHi,
  output logic          gateBLo,
  output logic          gateBHi
);

  strobe_t    strb;
  logic [3:0] gateQ;

  bgs_ctrl #(.CW(CW)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .dirIn(dirCmd), .hiEnIn(hiSideEn), .disIn(disReq), .uvIn(uvFlag),
    .riseHold(riseHold), .fallHold(fallHold),
    .refreshLen(refreshLen), .upperLen(upperLen),
    .strb(strb)
  );

  bgs_datapath #(.CW(CW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .hiDelay(hiDelay), .loDelay(loDelay),
    .gateQ(gateQ)
  );

  assign gateALo = gateQ[0];
  assign gateAHi = gateQ[1];
  assign gateBLo = gateQ[2];
  assign gateBHi = gateQ[3];

endmodule

// File: tb/sim_bridge_gate_seq.sv
`timescale 1ns/1ps
module sim_bridge_gate_seq;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN = 1'b0;
  logic dirCmd = 1'b0, hiSideEn = 1'b1, disReq = 1'b1, uvFlag = 1'b0;
  logic [7:0] hiDelay = '0, loDelay = '0, riseHold = '0, fallHold = '0;
  logic [7:0] refreshLen = '0, upperLen = '0;
  logic gateALo, gateAHi, gateBLo, gateBHi;

  bridge_gate_seq #(.CW(8)) u0 (
    .clk(clk), .rstN(rstN), .dirCmd(dirCmd), .hiSideEn(hiSideEn),
    .disReq(disReq), .uvFlag(uvFlag), .hiDelay(hiDelay), .loDelay(loDelay),
    .riseHold(riseHold), .fallHold(fallHold), .refreshLen(refreshLen),
    .upperLen(upperLen), .gateALo(gateALo), .gateAHi(gateAHi),
    .gateBLo(gateBLo), .gateBHi(gateBHi)
  );

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;
  string tag = "R1";

  // ---- behavioural expectation built from the requirements ----
  logic [3:0] st1, st2;        // {dir, hen, dis, uv} after one / two flops
  logic mDir, mOff;
  int   mAge, mRel;
  logic [3:0] mOut;            // {BHi, BLo, AHi, ALo}
  int   mCnt [4];

  function automatic int refEff();
    return (refreshLen == 0) ? 1 : int'(refreshLen);
  endfunction

  function automatic int hiStart();
    return (int'(upperLen) > refEff()) ? int'(upperLen) : refEff();
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st1 <= 4'b0010; st2 <= 4'b0010;
      mDir <= 0; mAge <= 0; mOff <= 1; mRel <= 0; mOut <= '0;
      for (int k = 0; k < 4; k++) mCnt[k] <= 0;
    end else begin : mdl
      logic kill, offNow, refr, hiOk;
      logic [3:0] rq;
      int thr;
      kill   = st2[1] | st2[0];
      offNow = mOff | kill;
      refr   = !mOff && (mRel < refEff());
      hiOk   = !mOff && (mRel >= hiStart());
      rq[0] = !offNow && (refr || !mDir);
      rq[2] = !offNow && (refr || mDir);
      rq[1] = !offNow && !refr && hiOk && st2[2] && mDir;
      rq[3] = !offNow && !refr && hiOk && st2[2] && !mDir;
      for (int k = 0; k < 4; k++) begin
        int d;
        d = (k % 2 == 1) ? int'(hiDelay) : int'(loDelay);
        if (!rq[k]) begin
          mOut[k] <= 0; mCnt[k] <= 0;
        end else if (!mOut[k]) begin
          if (!mOut[k^1] && !rq[k^1] && (mCnt[k] >= d || (k % 2 == 0 && refr)))
            mOut[k] <= 1;
          else if (mCnt[k] < 1000)
            mCnt[k] <= mCnt[k] + 1;
        end
      end
      thr = st2[3] ? int'(riseHold) : int'(fallHold);
      if (st2[3] == mDir) mAge <= 0;
      else if (mAge >= thr) begin mDir <= st2[3]; mAge <= 0; end
      else mAge <= mAge + 1;
      if (kill) begin mOff <= 1; mRel <= 0; end
      else if (mOff) begin mOff <= 0; mRel <= 0; end
      else if (mRel < 1000) mRel <= mRel + 1;
      st1 <= {dirCmd, hiSideEn, disReq, uvFlag};
      st2 <= st1;
    end
  end

  // ---- comparison, away from the active edge ----
  always @(negedge clk) begin
    if (!done) begin
      logic [3:0] act;
      cyc++;
      act = {gateBHi, gateBLo, gateAHi, gateALo};
      checks++;
      if (act !== mOut) begin
        failures++;
        $display("FAIL %s cycle %0d gates(BH,BL,AH,AL) actual=%b expected=%b", tag, cyc, act, mOut);
      end
      checks++;  // R8 leg interlock
      if ((gateALo && gateAHi) || (gateBLo && gateBHi)) begin
        failures++;
        $display("FAIL R8 cycle %0d leg overlap actual=%b expected no leg with both on", cyc, act);
      end
      if (cyc > 190000) begin
        failures++;
        $display("FAIL watchdog actual=%0d cycles expected completion earlier", cyc);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic runCfg(input int hd, ld, rl, ul, rh, fh);
    @(negedge clk);
    rstN = 0; disReq = 1; uvFlag = 0; dirCmd = 0; hiSideEn = 1;
    hiDelay = 8'(hd); loDelay = 8'(ld); refreshLen = 8'(rl); upperLen = 8'(ul);
    riseHold = 8'(rh); fallHold = 8'(fh);
    tag = "R1"; hold(3);
    rstN = 1; hold(4);               // R1: still disabled, all low
    tag = "R2"; hold(2);
    disReq = 0;
    tag = "R9"; hold(rl + 6);        // refresh pulse on both lows
    tag = "R10"; hold(ul + 4);       // highs held back
    tag = "R4"; dirCmd = 1; hold(14); dirCmd = 0; hold(14);
    tag = "R6"; dirCmd = 1; hold(14); dirCmd = 0; hold(14);
    tag = "R7"; hiSideEn = 0; dirCmd = 1; hold(12); dirCmd = 0; hold(12); hiSideEn = 1; hold(12);
    tag = "R11";
    for (int w = 1; w <= 3; w++) begin
      dirCmd = 1; hold(w); dirCmd = 0; hold(12);
    end
    dirCmd = 1; hold(12);
    for (int w = 1; w <= 3; w++) begin
      dirCmd = 0; hold(w); dirCmd = 1; hold(12);
    end
    tag = "R5"; hiSideEn = 0; dirCmd = 0; hold(10); dirCmd = 1; hold(10);
    hiSideEn = 1; hold(10);
    tag = "R2"; disReq = 1; hold(8);
    disReq = 0;
    tag = "R12"; hold(3); disReq = 1; hold(5); disReq = 0; hold(4);
    tag = "R9"; hold(ul + rl + 12);
    tag = "R3"; uvFlag = 1; hold(6); uvFlag = 0; hold(ul + rl + 14);
  endtask

  initial begin
    for (int hd = 0; hd <= 2; hd++)
      for (int ld = 0; ld <= 2; ld++)
        for (int rl = 0; rl <= 3; rl += 3)
          for (int ul = 2; ul <= 6; ul += 4)
            for (int rh = 0; rh <= 2; rh += 2)
              for (int fh = 0; fh <= 1; fh++)
                runCfg(hd, ld, rl, ul, rh, fh);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule